// File: doc/BRIEF.md
# Dual Multi-Mode Timer/Counter

This block holds two 8-bit-register timer/counters, unit 0 and unit 1, in the classic two-timer arrangement of small microcontrollers. Each unit advances on a machine-cycle strobe (timer function) or on falling edges of its own external input, which is sampled on that strobe (counter function). A configuration register picks the count structure for each unit:

- a 13-bit count with a 5-bit prescaler,
- a full 16-bit count,
- an 8-bit count that reloads itself,
- a split mode in which unit 0 becomes two independent 8-bit counters,
- an 8-bit pulse-width mode with a 256-clock period.

Software reaches the configuration, count bytes and sticky overflow flags through a simple write port with a combinational read port. Each unit can drive its shared pin in one of two ways. In toggle mode the pin flips on every overflow and sits high until the first one. In pulse-width mode it carries the compare level. Overflows of unit 1 are also brought out as a one-cycle baud strobe for a serial port.

Top module: `dual_tmr_ctr`

Register addresses (byte wide):

| Address | Contents |
|---------|----------|
| 0 | configuration of unit 0 |
| 1 | configuration of unit 1 |
| 2 | low byte of unit 0 |
| 3 | high byte of unit 0 |
| 4 | low byte of unit 1 |
| 5 | high byte of unit 1 |
| 6 | flags |
| 7 | reads 0 |

Configuration bits:

| Bits | Field | Values |
|------|-------|--------|
| [2:0] | mode | 0 = 13-bit, 1 = 16-bit, 2 = reload, 3 = split, 6 = pulse-width |
| [3] | source | 1 = counter |
| [4] | run | |
| [5] | toggle enable | |
| [7:6] | unused | read 0 |

Flags: bit 0 belongs to unit 0 and bit 1 to unit 1.

## Requirements
- R1: After reset every register reads 0, both pins output 1 with their enables low, no flag is set and the baud strobe is low.
- R2: Writes land in the addressed register, and reads return it, with configuration bits [7:6] reading 0 and address 7 reading 0. A byte write in the same cycle as a count step wins over the step.
- R3: In timer function with run set, the count advances exactly once per cycle that carries the machine-cycle strobe. It holds when run is clear or no strobe arrives.
- R4: In counter function the count advances on a strobe cycle where the input is 0 and the input sampled at the previous strobe was 1. A low pulse that starts and ends between two strobes is not counted.
- R5: Mode 0 counts low bits [4:0] as a prescaler that carries into the high byte. Low bits [7:5] are left unchanged, and 0x1FFF steps to 0 with an overflow.
- R6: Mode 1 counts {high, low} as 16 bits, and 0xFFFF steps to 0 with an overflow.
- R7: Mode 2 counts the low byte. From 0xFF it loads the high byte and overflows.
- R8: With unit 0 in mode 3, three things change. Its low byte wraps under its own run and source, raising flag 0. Its high byte counts strobes under unit 1's run bit and raises flag 1. Unit 1 then counts regardless of its run bit, and its overflows no longer set flag 1.
- R9: Unit 1 in mode 3 holds its count.
- R10: Mode 6 counts the low byte with a 256-step wrap that overflows. The pin is driven (enable 1), low while low < high and high otherwise.
- R11: Outside mode 6, with toggle enable set, the pin is driven and inverts one cycle after each overflow. While toggle enable is clear the pin level returns to 1 one cycle later, so it reads 1 when toggling is next turned on.
- R12: Each overflow sets its flag one cycle later, and the flag stays set. Writing 1 to a flag bit at address 6 clears it, writing 0 leaves it, and a new overflow in the clearing cycle wins.
- R13: The baud strobe is high for exactly the cycle after each overflow of unit 1.
- R14: Mode codes 4, 5 and 7 hold the count and raise no overflow.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low reset |
| mc_tick | input | 1 | machine-cycle strobe, one clock wide |
| ext_in | input | 2 | external count inputs, bit per unit |
| wr_en | input | 1 | register write strobe |
| addr | input | ADDR_W | register address |
| wr_data | input | BYTE_W | write data |
| rd_data | output | BYTE_W | read data for addr |
| pin_out | output | 2 | pin level per unit |
| pin_oe | output | 2 | pin drive enable per unit |
| ovf_flag | output | 2 | sticky overflow flags |
| baud_ovf | output | 1 | one-cycle strobe after each unit 1 overflow |

## Verification
The checks assume the machine-cycle strobe and the external inputs are synchronous to the clock, and that counts change only on strobe cycles or register writes. The stimulus therefore drives every input at the falling clock edge. It raises the strobe only inside the tick helper, and it changes configuration only through full-cycle writes. Overflow-to-flag and overflow-to-strobe timing is taken as exactly one cycle. Every expected value is derived from step counts applied between writes with the strobe low.

// File: rtl/tmr_pkg.sv
`timescale 1ns/1ps
package tmr_pkg;

   localparam int NUM_UNITS = 2;
   localparam int CFG_W     = 6;

   localparam logic [2:0] MODE_PRE13   = 3'd0;
   localparam logic [2:0] MODE_FULL16  = 3'd1;
   localparam logic [2:0] MODE_RELOAD8 = 3'd2;
   localparam logic [2:0] MODE_SPLIT   = 3'd3;
   localparam logic [2:0] MODE_PWM8    = 3'd6;

   typedef struct packed {
      logic       tog_en;
      logic       run;
      logic       cnt_sel;
      logic [2:0] mode;
   } tmr_cfg_t;

   localparam int ADDR_FLAGS = 6;

endpackage

// File: rtl/tmr_edge_det.sv
`timescale 1ns/1ps
module tmr_edge_det (
   input  logic clk,
   input  logic rst_n,
   input  logic tick,
   input  logic pin,
   output logic fall
);

   logic smp_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    smp_q <= 1'b0;
      else if (tick) smp_q <= pin;
   end

   // one-strobe-old sample high, current sample low
   assign fall = tick & smp_q & ~pin;

endmodule

// File: rtl/tmr_unit.sv
`timescale 1ns/1ps
module tmr_unit
   import tmr_pkg::*;
#(
   parameter int BYTE_W   = 8,
   parameter int PRESC_W  = 5,
   parameter bit SPLIT_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic              fall,
   input  tmr_cfg_t          cfg,
   input  logic              run_eff,
   input  logic              hi_run,
   input  logic              wr_lo,
   input  logic              wr_hi,
   input  logic [BYTE_W-1:0] wr_data,
   output logic [BYTE_W-1:0] lo_q,
   output logic [BYTE_W-1:0] hi_q,
   output logic              ovf,
   output logic              hi_ovf,
   output logic              pwm_lvl
);

   localparam logic [BYTE_W-1:0]  BYTE_ONES = '1;
   localparam logic [PRESC_W-1:0] PRE_ONES  = '1;

   logic              step;
   logic              hi_step;
   logic [BYTE_W-1:0] lo_nx;
   logic [BYTE_W-1:0] hi_nx;

   assign step    = run_eff & (cfg.cnt_sel ? fall : tick);
   assign hi_step = SPLIT_EN & tick & hi_run & (cfg.mode == MODE_SPLIT);

   always_comb begin
      lo_nx  = lo_q;
      hi_nx  = hi_q;
      ovf    = 1'b0;
      hi_ovf = 1'b0;
      case (cfg.mode)
         MODE_PRE13: begin
            if (step) begin
               if (lo_q[PRESC_W-1:0] == PRE_ONES) begin
                  lo_nx[PRESC_W-1:0] = '0;
                  hi_nx              = hi_q + 1'b1;
                  ovf                = (hi_q == BYTE_ONES);
               end else begin
                  lo_nx[PRESC_W-1:0] = lo_q[PRESC_W-1:0] + 1'b1;
               end
            end
         end
         MODE_FULL16: begin
            if (step) begin
               {hi_nx, lo_nx} = {hi_q, lo_q} + 1'b1;
               ovf            = (lo_q == BYTE_ONES) && (hi_q == BYTE_ONES);
            end
         end
         MODE_RELOAD8: begin
            if (step) begin
               if (lo_q == BYTE_ONES) begin
                  lo_nx = hi_q;
                  ovf   = 1'b1;
               end else begin
                  lo_nx = lo_q + 1'b1;
               end
            end
         end
         MODE_SPLIT: begin
            if (SPLIT_EN) begin
               if (step) begin
                  lo_nx = lo_q + 1'b1;
                  ovf   = (lo_q == BYTE_ONES);
               end
               if (hi_step) begin
                  hi_nx  = hi_q + 1'b1;
                  hi_ovf = (hi_q == BYTE_ONES);
               end
            end
         end
         MODE_PWM8: begin
            if (step) begin
               lo_nx = lo_q + 1'b1;
               ovf   = (lo_q == BYTE_ONES);
            end
         end
         default: begin
            lo_nx = lo_q;
            hi_nx = hi_q;
         end
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lo_q <= '0;
         hi_q <= '0;
      end else begin
         lo_q <= wr_lo ? wr_data : lo_nx;
         hi_q <= wr_hi ? wr_data : hi_nx;
      end
   end

   assign pwm_lvl = (lo_q >= hi_q);

endmodule

// File: rtl/tmr_toggle_out.sv
`timescale 1ns/1ps
module tmr_toggle_out (
   input  logic clk,
   input  logic rst_n,
   input  logic en,
   input  logic ovf,
   input  logic pwm_sel,
   input  logic pwm_lvl,
   output logic tog_state,
   output logic pin,
   output logic oe
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   tog_state <= 1'b1;
      else if (!en) tog_state <= 1'b1;
      else if (ovf) tog_state <= ~tog_state;
   end

   assign pin = pwm_sel ? pwm_lvl : tog_state;
   assign oe  = pwm_sel | en;

endmodule

// File: rtl/dual_tmr_ctr.sv
`timescale 1ns/1ps
module dual_tmr_ctr
   import tmr_pkg::*;
#(
   parameter int BYTE_W  = 8,
   parameter int PRESC_W = 5,
   parameter int ADDR_W  = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              mc_tick,
   input  logic [1:0]        ext_in,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [BYTE_W-1:0] wr_data,
   output logic [BYTE_W-1:0] rd_data,
   output logic [1:0]        pin_out,
   output logic [1:0]        pin_oe,
   output logic [1:0]        ovf_flag,
   output logic              baud_ovf
);

   localparam int PAD_CFG  = BYTE_W - CFG_W;
   localparam int PAD_FLAG = BYTE_W - NUM_UNITS;

   if (PRESC_W < 1 || PRESC_W >= BYTE_W) begin : g_bad_presc
      $error("PRESC_W must lie between 1 and BYTE_W-1");
   end
   if (BYTE_W < CFG_W) begin : g_bad_byte
      $error("BYTE_W too narrow for the configuration fields");
   end
   if (ADDR_W < 3) begin : g_bad_addr
      $error("ADDR_W must cover seven registers");
   end

   tmr_cfg_t                             cfg_v [NUM_UNITS];
   logic [NUM_UNITS-1:0][BYTE_W-1:0]     cnt_lo;
   logic [NUM_UNITS-1:0][BYTE_W-1:0]     cnt_hi;
   logic [NUM_UNITS-1:0]                 unit_ovf;
   logic [NUM_UNITS-1:0]                 unit_hi_ovf;
   logic [NUM_UNITS-1:0]                 tog_state;
   logic [NUM_UNITS-1:0]                 tog_en_v;
   logic                                 t0_split;
   logic [NUM_UNITS-1:0]                 flag_q;
   logic [NUM_UNITS-1:0]                 flag_set;
   logic [NUM_UNITS-1:0]                 flag_clr;
   logic                                 baud_q;

   assign t0_split = (cfg_v[0].mode == MODE_SPLIT);

   for (genvar u = 0; u < NUM_UNITS; u++) begin : g_unit
      tmr_cfg_t cfg_r;
      logic     fall;
      logic     run_eff;
      logic     hi_run;
      logic     pwm_lvl;
      logic     wr_cfg, wr_lo, wr_hi;

      assign wr_cfg = wr_en && (addr == ADDR_W'(u));
      assign wr_lo  = wr_en && (addr == ADDR_W'(2 + 2 * u));
      assign wr_hi  = wr_en && (addr == ADDR_W'(3 + 2 * u));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)      cfg_r <= '0;
         else if (wr_cfg) cfg_r <= tmr_cfg_t'(wr_data[CFG_W-1:0]);
      end
      assign cfg_v[u]    = cfg_r;
      assign tog_en_v[u] = cfg_r.tog_en;

      if (u == 0) begin : g_first
         assign run_eff = cfg_r.run;
         assign hi_run  = cfg_v[1].run;
      end else begin : g_other
         // unit 0 split: this unit runs unless parked in mode 3
         assign run_eff = cfg_r.run | t0_split;
         assign hi_run  = 1'b0;
      end

      tmr_edge_det u_edge (
         .clk  (clk),
         .rst_n(rst_n),
         .tick (mc_tick),
         .pin  (ext_in[u]),
         .fall (fall)
      );

      tmr_unit #(
         .BYTE_W  (BYTE_W),
         .PRESC_W (PRESC_W),
         .SPLIT_EN(u == 0)
      ) u_cnt (
         .clk    (clk),
         .rst_n  (rst_n),
         .tick   (mc_tick),
         .fall   (fall),
         .cfg    (cfg_r),
         .run_eff(run_eff),
         .hi_run (hi_run),
         .wr_lo  (wr_lo),
         .wr_hi  (wr_hi),
         .wr_data(wr_data),
         .lo_q   (cnt_lo[u]),
         .hi_q   (cnt_hi[u]),
         .ovf    (unit_ovf[u]),
         .hi_ovf (unit_hi_ovf[u]),
         .pwm_lvl(pwm_lvl)
      );

      tmr_toggle_out u_tog (
         .clk      (clk),
         .rst_n    (rst_n),
         .en       (cfg_r.tog_en),
         .ovf      (unit_ovf[u]),
         .pwm_sel  (cfg_r.mode == MODE_PWM8),
         .pwm_lvl  (pwm_lvl),
         .tog_state(tog_state[u]),
         .pin      (pin_out[u]),
         .oe       (pin_oe[u])
      );
   end

   // flag 1 is taken over by unit 0's high byte in split mode
   assign flag_set[0] = unit_ovf[0];
   assign flag_set[1] = t0_split ? unit_hi_ovf[0] : (unit_ovf[1] | unit_hi_ovf[1]);
   assign flag_clr    = (wr_en && addr == ADDR_W'(ADDR_FLAGS)) ? wr_data[NUM_UNITS-1:0] : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flag_q <= '0;
         baud_q <= 1'b0;
      end else begin
         flag_q <= (flag_q & ~flag_clr) | flag_set;
         baud_q <= unit_ovf[1];
      end
   end

   assign ovf_flag = flag_q;
   assign baud_ovf = baud_q;

   always_comb begin
      rd_data = '0;
      for (int u = 0; u < NUM_UNITS; u++) begin
         if (addr == ADDR_W'(u))         rd_data = {{PAD_CFG{1'b0}}, cfg_v[u]};
         if (addr == ADDR_W'(2 + 2 * u)) rd_data = cnt_lo[u];
         if (addr == ADDR_W'(3 + 2 * u)) rd_data = cnt_hi[u];
      end
      if (addr == ADDR_W'(ADDR_FLAGS)) rd_data = {{PAD_FLAG{1'b0}}, flag_q};
   end

endmodule

// File: rtl/tmr_chk.sv
`timescale 1ns/1ps
module tmr_chk #(
   parameter int BYTE_W    = 8,
   parameter int NUM_UNITS = 2
) (
   input logic                             clk,
   input logic                             rst_n,
   input logic                             mc_tick,
   input logic                             wr_en,
   input logic [NUM_UNITS-1:0]             unit_ovf,
   input logic [NUM_UNITS-1:0]             unit_hi_ovf,
   input logic                             t0_split,
   input logic [1:0]                       ovf_flag,
   input logic                             baud_ovf,
   input logic [NUM_UNITS-1:0][BYTE_W-1:0] cnt_lo,
   input logic [NUM_UNITS-1:0][BYTE_W-1:0] cnt_hi,
   input logic [NUM_UNITS-1:0]             tog_state,
   input logic [NUM_UNITS-1:0]             tog_en_v
);

   a_r12_flag0_set: assert property (@(posedge clk) disable iff (!rst_n)
      unit_ovf[0] |=> ovf_flag[0]);

   a_r8_split_flag1: assert property (@(posedge clk) disable iff (!rst_n)
      (t0_split && unit_hi_ovf[0]) |=> ovf_flag[1]);

   a_r8_hi_only_split: assert property (@(posedge clk) disable iff (!rst_n)
      (|unit_hi_ovf) |-> t0_split);

   a_r13_baud_follows: assert property (@(posedge clk) disable iff (!rst_n)
      unit_ovf[1] |=> baud_ovf);

   a_r13_baud_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !unit_ovf[1] |=> !baud_ovf);

   a_r3_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!mc_tick && !wr_en) |=> ($stable(cnt_lo) && $stable(cnt_hi)));

   a_r12_no_set_idle: assert property (@(posedge clk) disable iff (!rst_n)
      !mc_tick |=> ((ovf_flag & ~$past(ovf_flag)) == 2'b00));

   for (genvar u = 0; u < NUM_UNITS; u++) begin : g_tog
      a_r11_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
         !tog_en_v[u] |=> tog_state[u]);
   end

endmodule

bind dual_tmr_ctr tmr_chk #(
   .BYTE_W   (BYTE_W),
   .NUM_UNITS(tmr_pkg::NUM_UNITS)
) chk_i (
   .clk        (clk),
   .rst_n      (rst_n),
   .mc_tick    (mc_tick),
   .wr_en      (wr_en),
   .unit_ovf   (unit_ovf),
   .unit_hi_ovf(unit_hi_ovf),
   .t0_split   (t0_split),
   .ovf_flag   (ovf_flag),
   .baud_ovf   (baud_ovf),
   .cnt_lo     (cnt_lo),
   .cnt_hi     (cnt_hi),
   .tog_state  (tog_state),
   .tog_en_v   (tog_en_v)
);

// File: tb/dual_tmr_ctr_tb_top.sv
`timescale 1ns/1ps
module dual_tmr_ctr_tb_top;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       mc_tick = 1'b0;
   logic [1:0] ext_in = 2'b11;
   logic       wr_en = 1'b0;
   logic [2:0] addr = 3'd0;
   logic [7:0] wr_data = 8'd0;
   logic [7:0] rd_data;
   logic [1:0] pin_out;
   logic [1:0] pin_oe;
   logic [1:0] ovf_flag;
   logic       baud_ovf;

   int n_tests = 0;
   int n_fail  = 0;

   always #2.5 clk = ~clk;

   dual_tmr_ctr dut_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .mc_tick (mc_tick),
      .ext_in  (ext_in),
      .wr_en   (wr_en),
      .addr    (addr),
      .wr_data (wr_data),
      .rd_data (rd_data),
      .pin_out (pin_out),
      .pin_oe  (pin_oe),
      .ovf_flag(ovf_flag),
      .baud_ovf(baud_ovf)
   );

   // {req[47:44], mode[43:41], lo[40:33], hi[32:25], steps[24:17], exp_lo[16:9], exp_hi[8:1], exp_flag[0]}
   localparam int NVEC = 11;
   localparam logic [47:0] VECS [NVEC] = '{
      {4'd3,  3'd1, 8'h10, 8'h20, 8'd5,  8'h15, 8'h20, 1'b0}, // R3 plain stepping
      {4'd6,  3'd1, 8'hFE, 8'hFF, 8'd3,  8'h01, 8'h00, 1'b1}, // R6 16-bit wrap
      {4'd6,  3'd1, 8'hFF, 8'h12, 8'd1,  8'h00, 8'h13, 1'b0}, // R6 byte carry
      {4'd5,  3'd0, 8'hFE, 8'h05, 8'd3,  8'hE1, 8'h06, 1'b0}, // R5 prescaler carry
      {4'd5,  3'd0, 8'hBF, 8'hFF, 8'd1,  8'hA0, 8'h00, 1'b1}, // R5 13-bit wrap
      {4'd7,  3'd2, 8'hFD, 8'h80, 8'd4,  8'h81, 8'h80, 1'b1}, // R7 reload
      {4'd7,  3'd2, 8'h10, 8'h40, 8'd2,  8'h12, 8'h40, 1'b0}, // R7 no reload
      {4'd10, 3'd6, 8'hF0, 8'h30, 8'd32, 8'h10, 8'h30, 1'b1}, // R10 256 wrap
      {4'd14, 3'd4, 8'h12, 8'h34, 8'd9,  8'h12, 8'h34, 1'b0}, // R14 code 4
      {4'd14, 3'd5, 8'h56, 8'hFF, 8'd9,  8'h56, 8'hFF, 1'b0}, // R14 code 5
      {4'd14, 3'd7, 8'hFF, 8'hFF, 8'd9,  8'hFF, 8'hFF, 1'b0}  // R14 code 7
   };

   task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [2:0] a, input logic [7:0] d);
      @(negedge clk);
      wr_en = 1'b1; addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd(input logic [2:0] a, output logic [7:0] d);
      addr = a;
      #1;
      d = rd_data;
   endtask

   task automatic ticks(input int n);
      repeat (n) begin
         @(negedge clk);
         mc_tick = 1'b1;
      end
      @(negedge clk);
      mc_tick = 1'b0;
   endtask

   task automatic tick_ext(input logic v);
      @(negedge clk);
      ext_in[0] = v; mc_tick = 1'b1;
      @(negedge clk);
      mc_tick = 1'b0;
   endtask

   task automatic idle_ext(input logic v);
      @(negedge clk);
      ext_in[0] = v;
   endtask

   initial begin
      #900000;
      n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      logic [7:0] d;
      logic [7:0] d2;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      for (int a = 0; a < 8; a++) begin
         rd(3'(a), d);
         check("R1 reg", {8'h0, d}, 16'h0);
      end
      check("R1 pins", {14'h0, pin_out}, 16'h3);
      check("R1 oe", {14'h0, pin_oe}, 16'h0);
      check("R1 flags/baud", {13'h0, ovf_flag, baud_ovf}, 16'h0);

      // vector table, unit 0 in timer function
      for (int i = 0; i < NVEC; i++) begin
         logic [47:0] v;
         v = VECS[i];
         wr(3'd0, 8'h00);
         wr(3'd6, 8'h03);
         wr(3'd2, v[40:33]);
         wr(3'd3, v[32:25]);
         wr(3'd0, {5'b00010, v[43:41]});
         ticks(int'(v[24:17]));
         wr(3'd0, 8'h00);
         rd(3'd2, d);
         if (d !== v[16:9]) $display("  vector %0d R%0d low", i, v[47:44]);
         check("vector low", {8'h0, d}, {8'h0, v[16:9]});
         rd(3'd3, d);
         check("vector high", {8'h0, d}, {8'h0, v[8:1]});
         check("vector flag", {15'h0, ovf_flag[0]}, {15'h0, v[0]});
      end

      // R2 readback and write precedence
      wr(3'd1, 8'hFF);
      rd(3'd1, d);
      check("R2 cfg readback", {8'h0, d}, 16'h003F);
      rd(3'd7, d);
      check("R2 empty addr", {8'h0, d}, 16'h0);
      wr(3'd1, 8'h00);
      wr(3'd2, 8'h00);
      wr(3'd0, 8'h11);
      @(negedge clk);
      wr_en = 1'b1; addr = 3'd2; wr_data = 8'h55; mc_tick = 1'b1;
      @(negedge clk);
      wr_en = 1'b0; mc_tick = 1'b0;
      rd(3'd2, d);
      check("R2 write beats step", {8'h0, d}, 16'h0055);
      // R3 run clear holds
      wr(3'd0, 8'h01);
      ticks(4);
      rd(3'd2, d);
      check("R3 stopped holds", {8'h0, d}, 16'h0055);

      // R4 counter function on unit 0
      wr(3'd2, 8'h00);
      wr(3'd3, 8'h00);
      wr(3'd0, 8'h19);
      tick_ext(1'b1);
      tick_ext(1'b0);
      rd(3'd2, d);
      check("R4 first fall", {8'h0, d}, 16'h0001);
      tick_ext(1'b0);
      idle_ext(1'b1);
      idle_ext(1'b0);
      idle_ext(1'b1);
      tick_ext(1'b1);
      rd(3'd2, d);
      check("R4 short pulse ignored", {8'h0, d}, 16'h0001);
      tick_ext(1'b0);
      rd(3'd2, d);
      check("R4 second fall", {8'h0, d}, 16'h0002);
      ext_in[0] = 1'b1;
      wr(3'd0, 8'h00);

      // R8 split mode, phase A
      wr(3'd6, 8'h03);
      wr(3'd2, 8'hFE); wr(3'd3, 8'hFF);
      wr(3'd4, 8'hFF); wr(3'd5, 8'hFF);
      wr(3'd1, 8'h11);
      wr(3'd0, 8'h13);
      ticks(2);
      rd(3'd2, d); rd(3'd3, d2);
      check("R8 split bytes", {d2, d}, 16'h0100);
      check("R8 split flags", {14'h0, ovf_flag}, 16'h3);
      rd(3'd4, d); rd(3'd5, d2);
      check("R8 unit1 counts", {d2, d}, 16'h0001);
      // phase B: unit 1 ignores run, overflow only to baud
      wr(3'd1, 8'h01);
      wr(3'd6, 8'h03);
      wr(3'd4, 8'hFF); wr(3'd5, 8'hFF);
      ticks(1);
      check("R8 baud from unit1", {15'h0, baud_ovf}, 16'h1);
      check("R8 unit1 no flag", {14'h0, ovf_flag}, 16'h0);
      rd(3'd3, d); rd(3'd4, d2);
      check("R8 hi gated, unit1 wrapped", {d, d2}, 16'h0100);
      // phase C / R9: unit 1 parked in mode 3
      wr(3'd1, 8'h03);
      wr(3'd4, 8'h05);
      ticks(3);
      rd(3'd4, d);
      check("R9 parked while split", {8'h0, d}, 16'h0005);
      wr(3'd0, 8'h00);
      wr(3'd1, 8'h13);
      wr(3'd4, 8'h07);
      ticks(4);
      rd(3'd4, d);
      check("R9 mode 3 holds", {8'h0, d}, 16'h0007);
      check("R9 no flag", {15'h0, ovf_flag[1]}, 16'h0);

      // R13 baud strobe width
      wr(3'd1, 8'h00);
      wr(3'd6, 8'h03);
      wr(3'd4, 8'hFF); wr(3'd5, 8'hF0);
      wr(3'd1, 8'h12);
      check("R13 baud idle", {15'h0, baud_ovf}, 16'h0);
      ticks(1);
      check("R13 baud pulse", {15'h0, baud_ovf}, 16'h1);
      @(negedge clk);
      check("R13 baud one cycle", {15'h0, baud_ovf}, 16'h0);
      rd(3'd4, d);
      check("R13 reload value", {8'h0, d}, 16'h00F0);
      wr(3'd1, 8'h00);

      // R10 pulse-width output
      wr(3'd2, 8'h00); wr(3'd3, 8'h03);
      wr(3'd0, 8'h16);
      check("R10 low below compare", {14'h0, pin_oe[0], pin_out[0]}, 16'h2);
      ticks(2);
      check("R10 still below", {15'h0, pin_out[0]}, 16'h0);
      ticks(1);
      check("R10 reaches compare", {15'h0, pin_out[0]}, 16'h1);
      wr(3'd0, 8'h00);

      // R11 toggle output on unit 1
      wr(3'd4, 8'hFF); wr(3'd5, 8'hFE);
      wr(3'd1, 8'h32);
      check("R11 starts high", {14'h0, pin_oe[1], pin_out[1]}, 16'h3);
      ticks(1);
      check("R11 first toggle", {15'h0, pin_out[1]}, 16'h0);
      ticks(1);
      check("R11 no overflow", {15'h0, pin_out[1]}, 16'h0);
      ticks(1);
      check("R11 second toggle", {15'h0, pin_out[1]}, 16'h1);
      ticks(2);
      check("R11 third toggle", {15'h0, pin_out[1]}, 16'h0);
      wr(3'd1, 8'h02);
      @(negedge clk);
      check("R11 disabled high", {14'h0, pin_oe[1], pin_out[1]}, 16'h1);
      wr(3'd1, 8'h22);
      check("R11 reenabled high", {14'h0, pin_oe[1], pin_out[1]}, 16'h3);
      wr(3'd1, 8'h00);

      // R12 sticky flags and clear rules
      wr(3'd6, 8'h03);
      wr(3'd2, 8'hFF); wr(3'd3, 8'h00);
      wr(3'd0, 8'h12);
      ticks(1);
      check("R12 set", {15'h0, ovf_flag[0]}, 16'h1);
      ticks(3);
      rd(3'd6, d);
      check("R12 sticky", {8'h0, d}, 16'h0001);
      wr(3'd6, 8'h02);
      check("R12 zero keeps", {15'h0, ovf_flag[0]}, 16'h1);
      wr(3'd6, 8'h01);
      check("R12 one clears", {15'h0, ovf_flag[0]}, 16'h0);
      wr(3'd2, 8'hFF);
      @(negedge clk);
      wr_en = 1'b1; addr = 3'd6; wr_data = 8'h01; mc_tick = 1'b1;
      @(negedge clk);
      wr_en = 1'b0; mc_tick = 1'b0;
      check("R12 set beats clear", {15'h0, ovf_flag[0]}, 16'h1);

      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule